// File: doc/BRIEF.md
# Dual Timer-Counter with Mode and Control Registers

This block holds two 16-bit timer/counter channels and two external-interrupt request detectors, set up through a mode register and a control register on a small byte-wide register bus. Each channel steps either on an internal tick (one tick every `TICK_DIV` clocks) or on falling edges of its own count pin. Optionally a channel is qualified by its interrupt pin, so that it runs only while that pin is high. Four counting modes select a 13-bit prescaled counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, or a split mode. In split mode channel 0 becomes two independent 8-bit counters and channel 1 holds its value.

On overflow a channel sets its overflow flag. The interrupt detectors raise a request flag on a falling edge of their pin, or follow the pin level, as the control register selects. Software clears latched flags by a register write. The surrounding interrupt logic clears them with a one-cycle acknowledge pulse. All external pins pass through a two-flop synchronizer before use.

Top module: `tp_pair`

## Requirements
- R1: After synchronous reset every register reads 0x00, both overflow flags and both request flags are 0, and read data is 0x00.
- R2: Register addresses: 0 mode, 1 control, 2 channel-0 low byte, 3 channel-0 high byte, 4 channel-1 low byte, 5 channel-1 high byte. Read data is registered and shows the addressed register one clock after the address is presented. Mode layout per nibble, high to low: qualify, count-select, mode[1:0] (upper nibble channel 1, lower nibble channel 0). Control layout bit 7 to 0: ovf1, run1, ovf0, run0, req1, kind1, req0, kind0.
- R3: With count-select 0 a channel steps once per internal tick. With count-select 1 it steps once for each synchronized 1-then-0 transition of its count pin.
- R4: With qualify set, a channel steps only while its synchronized interrupt pin is high and its run bit is set.
- R5: With its run bit clear, a channel's count value holds.
- R6: Mode 0 counts 13 bits (low byte bits 4:0 under the high byte, low bits 7:5 untouched). Mode 1 counts 16 bits. Wrap from all ones to zero sets that channel's overflow flag.
- R7: Mode 2 counts the low byte. On a step at 0xFF it loads the high byte into the low byte and sets the overflow flag.
- R8: With channel 0 in mode 3, its low byte counts under channel-0 controls and sets ovf0, and its high byte counts internal ticks under run1 and sets ovf1. Channel 1 overflow then does not set ovf1. Channel 1 in mode 3 holds.
- R9: An overflow flag is cleared by a control write or by its acknowledge pulse. A hardware set in the same cycle wins over both.
- R10: With kind = 1 (edge), a request flag sets on a synchronized falling edge of its pin and stays set until acknowledged or cleared by a control write. A set wins.
- R11: With kind = 0 (level), a request flag equals the inverted synchronized pin one clock later; acknowledge and control writes do not change it.
- R12: A bus write to a count byte takes that value in the same cycle, overriding any step of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_pin | input | 2 | External count pins, one per channel |
| int_pin | input | 2 | External interrupt / qualify pins |
| tmr_ack | input | 2 | Overflow-interrupt acknowledge pulses |
| ext_ack | input | 2 | External-interrupt acknowledge pulses |
| tmr_flag | output | 2 | Overflow flags |
| ext_flag | output | 2 | External-interrupt request flags |

## Verification
A wrong count step, a missed reload or a bad synchronizer edge shows up as a count byte that drifts from the expected value. The drift reaches read data within one clock whenever that byte is addressed, and the flag outputs follow at the next wrap. A flag with a wrong priority between set, acknowledge and software write is visible on the flag outputs in the very next cycle. The bench therefore rotates the read address through all registers while comparing against a behavioural model every clock, so any divergence surfaces within six cycles.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {
    MD_13     = 2'd0,
    MD_16     = 2'd1,
    MD_RELOAD = 2'd2,
    MD_SPLIT  = 2'd3
  } tmode_e;

  localparam int          AW     = 3;
  localparam logic [2:0]  A_MODE = 3'd0;
  localparam logic [2:0]  A_CTRL = 3'd1;
  localparam logic [2:0]  A_LO0  = 3'd2;
  localparam logic [2:0]  A_HI0  = 3'd3;
  localparam logic [2:0]  A_LO1  = 3'd4;
  localparam logic [2:0]  A_HI1  = 3'd5;
endpackage

// File: rtl/tp_sync.sv
module tp_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);
  logic [W-1:0] s1;

  // pins idle high, so reset to 1 avoids a false falling edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= '1;
      lvl <= '1;
      prv <= '1;
    end else begin
      s1  <= din;
      lvl <= s1;
      prv <= lvl;
    end
  end
endmodule

// File: rtl/tp_flag.sv
module tp_flag (
  input  logic clk,
  input  logic rst,
  input  logic latch_mode,
  input  logic set,
  input  logic lvl_req,
  input  logic ack,
  input  logic sw_we,
  input  logic sw_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)             q <= 1'b0;
    else if (!latch_mode) q <= lvl_req;
    else if (set)        q <= 1'b1;
    else if (ack)        q <= 1'b0;
    else if (sw_we)      q <= sw_val;
  end
endmodule

// File: rtl/tp_chan.sv
module tp_chan
  import tp_pkg::*;
#(
  parameter bit SPLIT_CAP = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       ext_fall,
  input  logic       gate_lvl,
  input  logic       run_bit,
  input  logic       gate_en,
  input  logic       count_ext,
  input  logic [1:0] mode,
  input  logic       aux_run,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  output logic [7:0] lo_q,
  output logic [7:0] hi_q,
  output logic       ovf,
  output logic       aux_ovf
);
  tmode_e     md;
  logic       step, hstep;
  logic [7:0] lo_n, hi_n;

  assign md    = tmode_e'(mode);
  assign step  = run_bit && (!gate_en || gate_lvl) && (count_ext ? ext_fall : tick);
  assign hstep = SPLIT_CAP && (md == MD_SPLIT) && aux_run && tick;

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    ovf     = 1'b0;
    aux_ovf = 1'b0;
    if (step) begin
      case (md)
        MD_13: begin
          if (lo_q[4:0] == 5'h1f) begin
            lo_n[4:0] = 5'h00;
            hi_n      = hi_q + 8'd1;
            ovf       = (hi_q == 8'hff);
          end else begin
            lo_n[4:0] = lo_q[4:0] + 5'd1;
          end
        end
        MD_16: begin
          {hi_n, lo_n} = {hi_q, lo_q} + 16'd1;
          ovf          = &{hi_q, lo_q};
        end
        MD_RELOAD: begin
          if (lo_q == 8'hff) begin
            lo_n = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_n = lo_q + 8'd1;
          end
        end
        MD_SPLIT: begin
          if (SPLIT_CAP) begin
            lo_n = lo_q + 8'd1;
            ovf  = &lo_q;
          end
        end
        default: ;
      endcase
    end
    if (hstep) begin
      hi_n    = hi_q + 8'd1;
      aux_ovf = &hi_q;
    end
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 8'h00;
      hi_q <= 8'h00;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/tp_pair.sv
module tp_pair
  import tp_pkg::*;
#(
  parameter int TICK_DIV = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    int_pin,
  input  logic [1:0]    tmr_ack,
  input  logic [1:0]    ext_ack,
  output logic [1:0]    tmr_flag,
  output logic [1:0]    ext_flag
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [7:0]      mode_q;
  logic [1:0]      tr_q, it_q;
  logic [3:0]      s_lvl, s_prv;
  logic [1:0]      int_lvl, int_fall, cnt_fall;
  logic [TW-1:0]   tcnt;
  logic            tick, ctrl_we, t0split;
  logic [1:0][7:0] cnt_lo, cnt_hi;
  logic [1:0]      ch_ovf, ch_aux, tf_set;

  tp_sync #(.W(4)) u_sync (
    .clk (clk), .rst (rst), .din ({int_pin, cnt_pin}), .lvl (s_lvl), .prv (s_prv)
  );

  assign int_lvl  = s_lvl[3:2];
  assign int_fall = s_prv[3:2] & ~s_lvl[3:2];
  assign cnt_fall = s_prv[1:0] & ~s_lvl[1:0];

  assign tick = (tcnt == TW'(TICK_DIV - 1));
  always_ff @(posedge clk) begin
    if (rst || tick) tcnt <= '0;
    else             tcnt <= tcnt + 1'b1;
  end

  assign ctrl_we = bus_we && (bus_addr == A_CTRL);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 8'h00;
      tr_q   <= 2'b00;
      it_q   <= 2'b00;
    end else begin
      if (bus_we && (bus_addr == A_MODE)) mode_q <= bus_wdata;
      if (ctrl_we) begin
        tr_q <= {bus_wdata[6], bus_wdata[4]};
        it_q <= {bus_wdata[2], bus_wdata[0]};
      end
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_ch
    localparam logic [2:0] ALO = A_LO0 + 3'(2 * gi);
    localparam logic [2:0] AHI = A_HI0 + 3'(2 * gi);
    tp_chan #(.SPLIT_CAP(gi == 0)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .ext_fall  (cnt_fall[gi]),
      .gate_lvl  (int_lvl[gi]),
      .run_bit   (tr_q[gi]),
      .gate_en   (mode_q[4*gi+3]),
      .count_ext (mode_q[4*gi+2]),
      .mode      (mode_q[4*gi +: 2]),
      .aux_run   (tr_q[1]),
      .wr_lo     (bus_we && (bus_addr == ALO)),
      .wr_hi     (bus_we && (bus_addr == AHI)),
      .wdata     (bus_wdata),
      .lo_q      (cnt_lo[gi]),
      .hi_q      (cnt_hi[gi]),
      .ovf       (ch_ovf[gi]),
      .aux_ovf   (ch_aux[gi])
    );
  end

  // split mode on channel 0 hands the ovf1 source to its high byte
  assign t0split   = (tmode_e'(mode_q[1:0]) == MD_SPLIT);
  assign tf_set[0] = ch_ovf[0];
  assign tf_set[1] = t0split ? ch_aux[0] : (ch_ovf[1] | ch_aux[1]);

  for (genvar gk = 0; gk < 2; gk++) begin : g_flag
    tp_flag u_tf (
      .clk (clk), .rst (rst), .latch_mode (1'b1), .set (tf_set[gk]),
      .lvl_req (1'b0), .ack (tmr_ack[gk]), .sw_we (ctrl_we),
      .sw_val (bus_wdata[5+2*gk]), .q (tmr_flag[gk])
    );
    tp_flag u_ie (
      .clk (clk), .rst (rst), .latch_mode (it_q[gk]), .set (int_fall[gk]),
      .lvl_req (!int_lvl[gk]), .ack (ext_ack[gk]), .sw_we (ctrl_we),
      .sw_val (bus_wdata[1+2*gk]), .q (ext_flag[gk])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 8'h00;
    else begin
      case (bus_addr)
        A_MODE:  bus_rdata <= mode_q;
        A_CTRL:  bus_rdata <= {tmr_flag[1], tr_q[1], tmr_flag[0], tr_q[0],
                               ext_flag[1], it_q[1], ext_flag[0], it_q[0]};
        A_LO0:   bus_rdata <= cnt_lo[0];
        A_HI0:   bus_rdata <= cnt_hi[0];
        A_LO1:   bus_rdata <= cnt_lo[1];
        A_HI1:   bus_rdata <= cnt_hi[1];
        default: bus_rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/tp_pair_chk.sv
module tp_pair_chk (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [1:0]      tmr_ack,
  input logic [1:0]      tmr_flag,
  input logic [1:0]      ext_flag,
  input logic [1:0]      tf_set,
  input logic [1:0]      tr_q,
  input logic [1:0]      it_q,
  input logic [1:0]      int_lvl,
  input logic [1:0]      int_fall,
  input logic [7:0]      mode_q,
  input logic [1:0][7:0] cnt_lo
);
  AST_TF_HW_SET: assert property (@(posedge clk) disable iff (rst)
    tf_set[0] |=> tmr_flag[0]); // R9
  AST_TF_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (tmr_ack[0] && !tf_set[0]) |=> !tmr_flag[0]); // R9
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!tr_q[0] && !(bus_we && bus_addr == 3'd2)) |=> $stable(cnt_lo[0])); // R5
  AST_GATE_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode_q[3] && !int_lvl[0] && !(bus_we && bus_addr == 3'd2)) |=> $stable(cnt_lo[0])); // R4
  AST_EDGE_REQ_SET: assert property (@(posedge clk) disable iff (rst)
    (it_q[0] && int_fall[0]) |=> ext_flag[0]); // R10
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !it_q[1] |=> (ext_flag[1] == !$past(int_lvl[1]))); // R11
  AST_T1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_q[5:4] == 2'd3 && !(bus_we && bus_addr == 3'd4)) |=> $stable(cnt_lo[1])); // R8
endmodule

bind tp_pair tp_pair_chk u_chk (
  .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
  .tmr_ack (tmr_ack), .tmr_flag (tmr_flag), .ext_flag (ext_flag),
  .tf_set (tf_set), .tr_q (tr_q), .it_q (it_q), .int_lvl (int_lvl),
  .int_fall (int_fall), .mode_q (mode_q), .cnt_lo (cnt_lo)
);

// File: tb/tp_pair_tb_top.sv
module tp_pair_tb_top;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = 2'b11, int_pin = 2'b11, tmr_ack = 2'b00, ext_ack = 2'b00;
  logic [1:0] tmr_flag, ext_flag;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  tp_pair #(.TICK_DIV(DIV)) dut_i (
    .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .cnt_pin (cnt_pin),
    .int_pin (int_pin), .tmr_ack (tmr_ack), .ext_ack (ext_ack),
    .tmr_flag (tmr_flag), .ext_flag (ext_flag)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int s1[4], s2[4], s3[4];
  int m_div, m_mode, m_rd;
  int m_tr[2], m_it[2], m_tf[2], m_ie[2], m_lo[2], m_hi[2];

  function automatic int m_read(int a);
    case (a)
      0: return m_mode;
      1: return m_tf[1]*128 + m_tr[1]*64 + m_tf[0]*32 + m_tr[0]*16 +
                m_ie[1]*8 + m_it[1]*4 + m_ie[0]*2 + m_it[0];
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic m_step(int c, int md, output int ov);
    int v;
    ov = 0;
    case (md)
      0: begin
        v = m_hi[c]*32 + (m_lo[c] % 32);
        if (v == 8191) ov = 1;
        v = (v + 1) % 8192;
        m_hi[c] = v / 32;
        m_lo[c] = (m_lo[c] / 32) * 32 + v % 32;
      end
      1: begin
        v = m_hi[c]*256 + m_lo[c];
        if (v == 65535) ov = 1;
        v = (v + 1) % 65536;
        m_hi[c] = v / 256;
        m_lo[c] = v % 256;
      end
      2: begin
        if (m_lo[c] == 255) begin m_lo[c] = m_hi[c]; ov = 1; end
        else m_lo[c] = m_lo[c] + 1;
      end
      default: begin
        if (c == 0) begin
          if (m_lo[0] == 255) ov = 1;
          m_lo[0] = (m_lo[0] + 1) % 256;
        end
      end
    endcase
  endtask

  always @(posedge clk) begin
    int fall[4], lvl[4], ov[2], aux0, tick, nrd, md[2], st, a, d;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin s1[i] = 1; s2[i] = 1; s3[i] = 1; end
      m_div = 0; m_mode = 0; m_rd = 0;
      for (int k = 0; k < 2; k++) begin
        m_tr[k] = 0; m_it[k] = 0; m_tf[k] = 0; m_ie[k] = 0; m_lo[k] = 0; m_hi[k] = 0;
      end
    end else begin
      a = int'(bus_addr); d = int'(bus_wdata);
      for (int i = 0; i < 4; i++) begin
        lvl[i]  = s2[i];
        fall[i] = (s3[i] == 1 && s2[i] == 0) ? 1 : 0;
      end
      tick = (m_div == DIV - 1) ? 1 : 0;
      nrd  = m_read(a);
      aux0 = 0;
      for (int k = 0; k < 2; k++) begin
        md[k] = (m_mode >> (4*k)) % 4;
        ov[k] = 0;
        st = m_tr[k] != 0 && (((m_mode >> (4*k+3)) % 2) == 0 || lvl[2+k] == 1) &&
             ((((m_mode >> (4*k+2)) % 2) == 1) ? fall[k] == 1 : tick == 1);
        if (st && !(k == 1 && md[1] == 3)) m_step(k, md[k], ov[k]);
      end
      if (md[0] == 3 && m_tr[1] == 1 && tick == 1) begin
        if (m_hi[0] == 255) aux0 = 1;
        m_hi[0] = (m_hi[0] + 1) % 256;
      end
      if (bus_we) begin
        if (a == 2) m_lo[0] = d;
        if (a == 3) m_hi[0] = d;
        if (a == 4) m_lo[1] = d;
        if (a == 5) m_hi[1] = d;
      end
      for (int k = 0; k < 2; k++) begin
        int setf;
        setf = (k == 0) ? ov[0] : ((md[0] == 3) ? aux0 : ov[1]);
        if (bus_we && a == 1) m_tf[k] = (d >> (5+2*k)) % 2;
        if (tmr_ack[k]) m_tf[k] = 0;
        if (setf == 1) m_tf[k] = 1;
        if (m_it[k] == 1) begin
          if (bus_we && a == 1) m_ie[k] = (d >> (1+2*k)) % 2;
          if (ext_ack[k]) m_ie[k] = 0;
          if (fall[2+k] == 1) m_ie[k] = 1;
        end else begin
          m_ie[k] = 1 - lvl[2+k];
        end
      end
      if (bus_we && a == 0) m_mode = d;
      if (bus_we && a == 1) begin
        m_tr[0] = (d >> 4) % 2; m_tr[1] = (d >> 6) % 2;
        m_it[0] = d % 2;        m_it[1] = (d >> 2) % 2;
      end
      m_rd  = nrd;
      m_div = (tick == 1) ? 0 : m_div + 1;
      for (int i = 0; i < 4; i++) begin
        s3[i] = s2[i]; s2[i] = s1[i];
        s1[i] = (i < 2) ? int'(cnt_pin[i]) : int'(int_pin[i-2]);
      end
    end
    #2;
    checks += 3;
    if (int'(bus_rdata) != m_rd) begin
      errors++;
      $display("FAIL %s rdata act=%0h exp=%0h", cur_req, bus_rdata, m_rd);
    end
    if (int'(tmr_flag) != m_tf[1]*2 + m_tf[0]) begin
      errors++;
      $display("FAIL %s tmr_flag act=%0b exp=%0d%0d", cur_req, tmr_flag, m_tf[1], m_tf[0]);
    end
    if (int'(ext_flag) != m_ie[1]*2 + m_ie[0]) begin
      errors++;
      $display("FAIL %s ext_flag act=%0b exp=%0d%0d", cur_req, ext_flag, m_ie[1], m_ie[0]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[2:0]; bus_wdata = d[7:0];
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      bus_addr = (bus_addr == 3'd5) ? 3'd0 : bus_addr + 3'd1;
    end
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); bus_addr = a[2:0];
    @(negedge clk); v = int'(bus_rdata);
  endtask

  task automatic cnt_pulse(int k);
    @(negedge clk); cnt_pin[k] = 1'b0;
    idle(3); cnt_pin[k] = 1'b1;
    idle(3);
  endtask

  task automatic pulse_ack(bit tmr, int k);
    @(negedge clk);
    if (tmr) tmr_ack[k] = 1'b1; else ext_ack[k] = 1'b1;
    @(negedge clk);
    tmr_ack = 2'b00; ext_ack = 2'b00;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    chk("tmr_flag after reset", int'(tmr_flag), 0);
    chk("ext_flag after reset", int'(ext_flag), 0);
    rd(1, v); chk("ctrl after reset", v, 0);
    idle(8);

    cur_req = "R2";
    wr(2, 8'h5A); rd(2, v); chk("lo0 readback", v, 8'h5A);
    wr(0, 8'hA5); rd(0, v); chk("mode readback", v, 8'hA5);
    wr(0, 8'h00); idle(6);

    cur_req = "R6";
    wr(0, 8'h01); wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h10);
    idle(70);
    chk("ovf0 after 16-bit wrap", int'(tmr_flag[0]), 1);

    cur_req = "R9";
    pulse_ack(1'b1, 0);
    chk("ovf0 after ack", int'(tmr_flag[0]), 0);
    wr(1, 8'h30); chk("ovf0 after sw set", int'(tmr_flag[0]), 1);
    wr(1, 8'h10); chk("ovf0 after sw clear", int'(tmr_flag[0]), 0);

    cur_req = "R5";
    wr(1, 8'h00); rd(2, v); idle(20); rd(2, v2);
    chk("lo0 holds when stopped", v2, v);

    cur_req = "R7";
    wr(0, 8'h02); wr(3, 8'hFC); wr(2, 8'hFE); wr(1, 8'h10);
    idle(40);
    rd(2, v); chk("lo0 in reload range", (v >= 8'hFC) ? 1 : 0, 1);
    chk("ovf0 on reload", int'(tmr_flag[0]), 1);

    cur_req = "R6";
    wr(1, 8'h00); wr(0, 8'h00); wr(3, 8'hFF); wr(2, 8'h1C); wr(1, 8'h10);
    idle(30);
    chk("ovf0 after 13-bit wrap", int'(tmr_flag[0]), 1);
    rd(2, v); chk("lo0 upper bits untouched", v / 32, 0);

    cur_req = "R3";
    wr(1, 8'h00); wr(0, 8'h05); wr(2, 0); wr(3, 0); wr(1, 8'h10);
    for (int i = 0; i < 5; i++) cnt_pulse(0);
    idle(4); rd(2, v); chk("lo0 counted 5 edges", v, 5);

    cur_req = "R4";
    wr(0, 8'h0D); wr(2, 0);
    @(negedge clk); int_pin[0] = 1'b0; idle(4);
    for (int i = 0; i < 3; i++) cnt_pulse(0);
    rd(2, v); chk("lo0 blocked by gate", v, 0);
    @(negedge clk); int_pin[0] = 1'b1; idle(4);
    for (int i = 0; i < 4; i++) cnt_pulse(0);
    idle(4); rd(2, v); chk("lo0 counts with gate high", v, 4);

    cur_req = "R8";
    wr(1, 8'h00); wr(0, 8'h13);
    wr(2, 8'hFE); wr(3, 8'h00); wr(4, 8'hFE); wr(5, 8'hFF);
    wr(1, 8'h50);
    idle(30);
    chk("ovf1 not from channel 1 in split", int'(tmr_flag[1]), 0);
    chk("ovf0 from split low byte", int'(tmr_flag[0]), 1);
    wr(3, 8'hFE); idle(12);
    chk("ovf1 from split high byte", int'(tmr_flag[1]), 1);
    wr(0, 8'h33); rd(4, v); idle(15); rd(4, v2);
    chk("channel 1 holds in mode 3", v2, v);

    cur_req = "R9";
    wr(1, 8'h00); wr(0, 8'h06); wr(2, 8'hFF); wr(3, 8'h00); wr(1, 8'h10);
    idle(3);
    @(negedge clk); cnt_pin[0] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h10;
    @(negedge clk); bus_we = 1'b0;
    chk("hw set wins over sw clear", int'(tmr_flag[0]), 1);
    cnt_pin[0] = 1'b1; idle(4);

    cur_req = "R10";
    wr(1, 8'h05); idle(4);
    @(negedge clk); int_pin[1] = 1'b0; idle(5);
    chk("req1 after falling edge", int'(ext_flag[1]), 1);
    @(negedge clk); int_pin[1] = 1'b1; idle(5);
    chk("req1 latched after pin high", int'(ext_flag[1]), 1);
    pulse_ack(1'b0, 1);
    chk("req1 after ack", int'(ext_flag[1]), 0);
    @(negedge clk); int_pin[0] = 1'b0; idle(5);
    chk("req0 after falling edge", int'(ext_flag[0]), 1);
    wr(1, 8'h05);
    chk("req0 after sw clear", int'(ext_flag[0]), 0);
    @(negedge clk); int_pin[0] = 1'b1; idle(5);

    cur_req = "R11";
    wr(1, 8'h00); idle(4);
    chk("req0 level idle", int'(ext_flag[0]), 0);
    @(negedge clk); int_pin[0] = 1'b0; idle(5);
    chk("req0 level low", int'(ext_flag[0]), 1);
    pulse_ack(1'b0, 0);
    chk("req0 level ignores ack", int'(ext_flag[0]), 1);
    wr(1, 8'h00);
    chk("req0 level ignores sw write", int'(ext_flag[0]), 1);
    @(negedge clk); int_pin[0] = 1'b1; idle(5);
    chk("req0 level released", int'(ext_flag[0]), 0);

    cur_req = "R12";
    wr(0, 8'h01); wr(3, 8'h00); wr(1, 8'h10); idle(7);
    wr(2, 8'h33); rd(2, v);
    chk("lo0 write overrides step", (v == 8'h33 || v == 8'h34) ? 1 : 0, 1);
    idle(20);

    finish_run();
  end
endmodule